// File: doc/BRIEF.md
# Bernoulli Error-Pattern Vector Generator

This block builds a wide vector of error bits. Each bit is set on its own with a probability chosen by software, and that choice is written as a 32-bit threshold. A set of parallel lanes makes the bits. Each lane is a seeded 32-bit xorshift source that gives one uniform word per cycle, and the lane compares that word against the threshold. On each cycle every lane writes one bit, so a vector of `VEC_W` bits is complete after `VEC_W/LANES` cycles.

A user loads one seed per lane, sets the threshold and pulses `start_i`. The block then fills the vector and pulses `done_o` for one cycle. The vector keeps its value until the next start. The `LANES` parameter sets how much logic is spent against how long a fill takes: one lane needs one cycle per bit, and many lanes finish in a few cycles. The reset input is asynchronous and active low. Inside the block it is released in step with the clock.

Top module: `bern_vec_gen`

## Requirements
- R1: While reset is held and after it is released, `vec_o` is all zeros and `done_o` is low until the first fill completes.
- R2: A bit is 1 when its 32-bit sample, read as unsigned, is strictly less than the threshold, and 0 otherwise. A sample equal to the threshold gives 0.
- R3: On fill cycle c (counting from 0), lane k writes bit c·LANES + k. `done_o` is high in exactly the (VEC_W/LANES + 1)-th clock cycle after the edge that samples `start_i`.
- R4: The first sample of lane k is its seed `seeds_i[32k +: 32]`. Each following sample comes from the previous one by x ^= x<<13, then x ^= x>>17, then x ^= x<<5.
- R5: A lane whose seed is zero uses the seed 32'h2545F491 instead.
- R6: The threshold is captured on the start edge. Changes to `thresh_i` and `seeds_i` during a fill have no effect on the vector.
- R7: A `start_i` pulse during a fill is ignored. It does not restart the fill, load new seeds or produce an extra `done_o`.
- R8: `done_o` is high for a single cycle. `vec_o` holds its value from `done_o` until the next accepted start.
- R9: A threshold of 0 gives an all-zero vector. A threshold of all ones gives all ones, except for bits whose sample is 32'hFFFFFFFF.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| seeds_i | input | 32·LANES | One seed per lane; lane k occupies bits 32k+31:32k |
| thresh_i | input | 32 | Probability threshold, p·(2^32−1) |
| start_i | input | 1 | Start a fill (accepted only when idle) |
| vec_o | output | VEC_W | Completed error-pattern vector |
| done_o | output | 1 | One-cycle pulse when the last bit is written |

## Verification
The bench builds the block with VEC_W = 1024 and LANES = 8, so one fill takes 128 cycles. With eight lanes, one vector can exercise lane interleaving, the replacement of a zero seed in a single lane, and the equal and off-by-one cases of the comparison at chosen bit positions, all at once. A fill this short also leaves time to re-pulse start and change the threshold partway through a fill, and then to check that the result has not moved.

// File: rtl/bvg_pkg.sv
package bvg_pkg;
  localparam int          WORD_W    = 32;
  localparam logic [31:0] ZERO_SUB  = 32'h2545F491;

  // one step of the 13/17/5 xorshift recurrence
  function automatic logic [WORD_W-1:0] xs_step(input logic [WORD_W-1:0] x);
    logic [WORD_W-1:0] t;
    t = x ^ (x << 13);
    t = t ^ (t >> 17);
    t = t ^ (t << 5);
    return t;
  endfunction

  // a zero state would lock the generator, swap in a fixed constant
  function automatic logic [WORD_W-1:0] fix_seed(input logic [WORD_W-1:0] s);
    return (s == '0) ? ZERO_SUB : s;
  endfunction
endpackage

// File: rtl/bvg_ctrl.sv
module bvg_ctrl
  import bvg_pkg::*;
#(
  parameter int FILL = 256
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_i,
  input  logic [WORD_W-1:0] thresh_i,
  output logic              load_o,
  output logic              adv_o,
  output logic [((FILL > 1) ? $clog2(FILL) : 1)-1:0] cnt_o,
  output logic              busy_o,
  output logic [WORD_W-1:0] thr_o,
  output logic              done_o
);
  localparam int CW = (FILL > 1) ? $clog2(FILL) : 1;
  localparam logic [CW-1:0] LAST_IDX = CW'(FILL - 1);

  logic              busy_q, busy_d;
  logic [CW-1:0]     cnt_q, cnt_d;
  logic [WORD_W-1:0] thr_q, thr_d;
  logic              done_q, done_d;
  logic              load, last;

  always_comb begin
    load   = start_i && !busy_q;
    last   = busy_q && (cnt_q == LAST_IDX);
    busy_d = busy_q;
    cnt_d  = cnt_q;
    thr_d  = thr_q;
    done_d = last;
    if (load) begin
      busy_d = 1'b1;
      cnt_d  = '0;
      thr_d  = thresh_i;
    end else if (busy_q) begin
      cnt_d = last ? '0 : cnt_q + CW'(1);
      if (last) busy_d = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      cnt_q  <= '0;
      thr_q  <= '0;
      done_q <= 1'b0;
    end else begin
      busy_q <= busy_d;
      cnt_q  <= cnt_d;
      thr_q  <= thr_d;
      done_q <= done_d;
    end
  end

  assign load_o = load;
  assign adv_o  = busy_q;
  assign cnt_o  = cnt_q;
  assign busy_o = busy_q;
  assign thr_o  = thr_q;
  assign done_o = done_q;
endmodule

// File: rtl/bvg_lane.sv
module bvg_lane
  import bvg_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load_i,
  input  logic              adv_i,
  input  logic [WORD_W-1:0] seed_i,
  input  logic [WORD_W-1:0] thr_i,
  output logic              bit_o
);
  logic [WORD_W-1:0] st_q, st_d;

  always_comb begin
    st_d = st_q;
    if (load_i)     st_d = fix_seed(seed_i);
    else if (adv_i) st_d = xs_step(st_q);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) st_q <= ZERO_SUB;
    else        st_q <= st_d;
  end

  // the current state is this cycle's uniform sample
  assign bit_o = (st_q < thr_i);
endmodule

// File: rtl/bvg_assemble.sv
module bvg_assemble #(
  parameter int VEC_W = 1024,
  parameter int LANES = 4,
  parameter int CW    = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en_i,
  input  logic [CW-1:0]    idx_i,
  input  logic [LANES-1:0] bits_i,
  output logic [VEC_W-1:0] vec_o
);
  logic [VEC_W-1:0] vec_q, vec_d;
  int unsigned base;

  always_comb begin
    vec_d = vec_q;
    base  = 32'(idx_i) * 32'(LANES);
    if (wr_en_i) vec_d[base +: LANES] = bits_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) vec_q <= '0;
    else        vec_q <= vec_d;
  end

  assign vec_o = vec_q;
endmodule

// File: rtl/bern_vec_gen.sv
module bern_vec_gen
  import bvg_pkg::*;
#(
  parameter int VEC_W = 1024,
  parameter int LANES = 4   // must divide VEC_W
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic [WORD_W*LANES-1:0] seeds_i,
  input  logic [WORD_W-1:0]       thresh_i,
  input  logic                    start_i,
  output logic [VEC_W-1:0]        vec_o,
  output logic                    done_o
);
  localparam int FILL = VEC_W / LANES;
  localparam int CW   = (FILL > 1) ? $clog2(FILL) : 1;

  // asynchronous assert, clocked release
  logic [1:0] rsync_q;
  logic       rst_core_n;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rsync_q <= 2'b00;
    else        rsync_q <= {rsync_q[0], 1'b1};
  end
  assign rst_core_n = rsync_q[1];

  logic              load_w, adv_w, busy_w;
  logic [CW-1:0]     cnt_w;
  logic [WORD_W-1:0] thr_w;
  logic [LANES-1:0]  bits_w;

  bvg_ctrl #(.FILL(FILL)) u_ctrl (
    .clk      (clk),
    .rst_n    (rst_core_n),
    .start_i  (start_i),
    .thresh_i (thresh_i),
    .load_o   (load_w),
    .adv_o    (adv_w),
    .cnt_o    (cnt_w),
    .busy_o   (busy_w),
    .thr_o    (thr_w),
    .done_o   (done_o)
  );

  for (genvar k = 0; k < LANES; k++) begin : g_lane
    bvg_lane u_lane (
      .clk    (clk),
      .rst_n  (rst_core_n),
      .load_i (load_w),
      .adv_i  (adv_w),
      .seed_i (seeds_i[k*WORD_W +: WORD_W]),
      .thr_i  (thr_w),
      .bit_o  (bits_w[k])
    );
  end

  bvg_assemble #(.VEC_W(VEC_W), .LANES(LANES), .CW(CW)) u_asm (
    .clk     (clk),
    .rst_n   (rst_core_n),
    .wr_en_i (adv_w),
    .idx_i   (cnt_w),
    .bits_i  (bits_w),
    .vec_o   (vec_o)
  );
endmodule

// File: rtl/bvg_chk.sv
module bvg_chk #(
  parameter int VEC_W = 1024
) (
  input logic             clk,
  input logic             rst_n,
  input logic             start_i,
  input logic             done_o,
  input logic [VEC_W-1:0] vec_o,
  input logic             busy,
  input logic [31:0]      thr_q
);
  // R8
  done_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o);

  // R8
  vec_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && !start_i) |=> $stable(vec_o));

  // R6
  thr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> $stable(thr_q));

  // R3
  done_after_fill_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> !busy);

  // R9
  zero_thr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (done_o && thr_q == 32'd0) |-> (vec_o == '0));

  // R1
  reset_clear_chk: assert property (@(posedge clk)
    !rst_n |=> (!done_o));
endmodule

bind bern_vec_gen bvg_chk #(.VEC_W(VEC_W)) u_chk (
  .clk     (clk),
  .rst_n   (rst_n),
  .start_i (start_i),
  .done_o  (done_o),
  .vec_o   (vec_o),
  .busy    (busy_w),
  .thr_q   (thr_w)
);

// File: tb/bern_vec_gen_bench.sv
module bern_vec_gen_bench;
  localparam int VEC_W  = 1024;
  localparam int LANES  = 8;
  localparam int FILL   = VEC_W / LANES;
  localparam int T_CLK  = 10;
  localparam int WDOG   = 100000;

  logic                  clk = 1'b0;
  logic                  rst_n;
  logic [32*LANES-1:0]   seeds_i;
  logic [31:0]           thresh_i;
  logic                  start_i;
  logic [VEC_W-1:0]      vec_o;
  logic                  done_o;

  bern_vec_gen #(.VEC_W(VEC_W), .LANES(LANES)) u_bern_vec_gen (
    .clk (clk), .rst_n (rst_n), .seeds_i (seeds_i), .thresh_i (thresh_i),
    .start_i (start_i), .vec_o (vec_o), .done_o (done_o)
  );

  always #(T_CLK/2) clk = ~clk;

  int n_chk = 0, n_bad = 0, cyc = 0, done_seen = 0;
  bit finished = 0;
  logic [VEC_W-1:0] exp_q[$];
  int               st_q[$];
  string            tag_q[$];
  logic [VEC_W-1:0] last_vec;

  function automatic logic [31:0] ref_next(input logic [31:0] x);
    logic [31:0] y;
    y = x ^ (x << 13);
    y = y ^ (y >> 17);
    return y ^ (y << 5);
  endfunction

  // expected vector from R2, R3, R4, R5
  function automatic logic [VEC_W-1:0] ref_vec(input logic [32*LANES-1:0] sd,
                                                input logic [31:0] thr);
    logic [VEC_W-1:0] v;
    v = '0;
    for (int k = 0; k < LANES; k++) begin
      logic [31:0] s;
      s = sd[32*k +: 32];
      if (s == 32'd0) s = 32'h2545F491;
      for (int c = 0; c < FILL; c++) begin
        v[c*LANES + k] = (s < thr);
        s = ref_next(s);
      end
    end
    return v;
  endfunction

  task automatic check(input bit ok, input string tag, input string what,
                       input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: actual=%0d expected=%0d", tag, what, act, exp);
    end
  endtask

  task automatic report;
    if (!finished) begin
      finished = 1;
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  endtask

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > WDOG) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual=%0d expected<=%0d", cyc, WDOG);
      report();
    end
  end

  // monitor / scoreboard
  always @(negedge clk) begin
    if (rst_n && done_o) begin
      if (exp_q.size() == 0) begin
        check(0, "R7", "unexpected done", 1, 0);
      end else begin
        logic [VEC_W-1:0] e;
        int s;
        string t;
        e = exp_q.pop_front();
        s = st_q.pop_front();
        t = tag_q.pop_front();
        check(vec_o == e, t, "vector popcount", $countones(vec_o), $countones(e));
        check((cyc - s) == FILL + 1, "R3", "done latency", cyc - s, FILL + 1);
      end
      last_vec = vec_o;
      done_seen++;
    end
  end

  task automatic fire(input logic [32*LANES-1:0] sd, input logic [31:0] thr,
                      input string tag);
    @(negedge clk);
    seeds_i  = sd;
    thresh_i = thr;
    start_i  = 1'b1;
    exp_q.push_back(ref_vec(sd, thr));
    st_q.push_back(cyc);
    tag_q.push_back(tag);
    @(negedge clk);
    start_i = 1'b0;
  endtask

  task automatic wait_done(input int target);
    while (done_seen < target) @(negedge clk);
  endtask

  logic [32*LANES-1:0] sd;
  initial begin
    rst_n = 1'b0; start_i = 1'b0; seeds_i = '0; thresh_i = '0;
    repeat (3) @(negedge clk);
    // R1 during reset
    check(vec_o == '0, "R1", "vec in reset", $countones(vec_o), 0);
    check(done_o == 1'b0, "R1", "done in reset", done_o, 0);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);
    check(vec_o == '0, "R1", "vec after reset", $countones(vec_o), 0);
    check(done_o == 1'b0, "R1", "done after reset", done_o, 0);

    for (int k = 0; k < LANES; k++) sd[32*k +: 32] = 32'h1357_9BDF * (k + 3);
    fire(sd, 32'h8000_0000, "R2 R4");
    wait_done(1);

    // R8: stable after done, threshold change irrelevant
    thresh_i = 32'h0;
    repeat (6) @(negedge clk);
    check(vec_o == last_vec, "R8", "hold after done", $countones(vec_o), $countones(last_vec));
    check(done_o == 1'b0, "R8", "done single cycle", done_o, 0);

    fire(sd, 32'h0, "R9 zero");
    wait_done(2);
    check(vec_o == '0, "R9", "zero threshold", $countones(vec_o), 0);

    fire(sd, 32'hFFFF_FFFF, "R9 ones");
    wait_done(3);

    // R5: a zero seed in lane 3
    sd[32*3 +: 32] = 32'h0;
    fire(sd, 32'h4000_0000, "R5");
    wait_done(4);

    // R2 boundary: first sample equals seed, bit index = lane
    sd[0 +: 32]  = 32'h1234_5678;
    sd[32 +: 32] = 32'h1234_5677;
    sd[64 +: 32] = 32'h1234_5679;
    fire(sd, 32'h1234_5678, "R2 R3");
    wait_done(5);
    check(vec_o[0] == 1'b0, "R2", "sample equal to threshold", vec_o[0], 0);
    check(vec_o[1] == 1'b1, "R2", "sample one below threshold", vec_o[1], 1);
    check(vec_o[2] == 1'b0, "R2", "sample one above threshold", vec_o[2], 0);

    // R6 / R7: restart and input changes mid-fill
    for (int k = 0; k < LANES; k++) sd[32*k +: 32] = 32'hA5A5_0001 + 32'(k * 977);
    fire(sd, 32'h6000_0000, "R6 R7");
    repeat (30) @(negedge clk);
    thresh_i = 32'hFFFF_FFFF;
    seeds_i  = ~sd;
    start_i  = 1'b1;
    @(negedge clk);
    start_i  = 1'b0;
    wait_done(6);
    repeat (FILL + 10) @(negedge clk);
    check(done_seen == 6, "R7", "done count after ignored start", done_seen, 6);
    check(vec_o == last_vec, "R8", "hold until next start", $countones(vec_o), $countones(last_vec));

    report();
  end
endmodule